// File: doc/BRIEF.md
# Request/Acknowledge to Beat-Stream Width Converter

This block takes data words from a source that runs on its own timing and talks through a four-phase request/acknowledge handshake, and presents them in the system clock domain as a stream of narrow beats. Each input word is 27 bits: a 22-bit hit record in bits 21:0 and a 5-bit column address in bits 26:22. The request is passed through a multi-flop synchronizer. Once the synchronized request is high and the output side is free, the block samples the data bus, which the source holds steady while its request is up. In the same clock edge it raises acknowledge and starts sending the word.

The word is zero-extended at the top to a whole number of beats and sent most significant beat first, one beat per clock. A valid flag marks each beat and a start-of-frame flag marks the first. Acknowledge falls once the synchronized request has been seen low. A new word is not taken while beats of the previous one are still going out, so the source is held off through its handshake.

Top module: `hbs_conv_top`

## Requirements
- R1: While reset is asserted (active low, asynchronous), and after it is released until a request arrives, `ack_o`, `beat_valid_o` and `frame_start_o` are all low. A reset in the middle of a frame clears these outputs at once.
- R2: With the block idle, a request raised between clock edges produces `ack_o` high and the first beat valid after exactly the third rising edge. Before that edge both stay low.
- R3: `ack_o` stays high while the synchronized request is high. It falls after the third rising edge following the fall of `req_i`.
- R4: The word is zero-padded at the top to 32 bits (column address at bits 26:22, hit data at 21:0, bits 31:27 zero) and sent as four 8-bit beats, bits 31:24 first and bits 7:0 last, on consecutive cycles.
- R5: `frame_start_o` is high on the first beat of each word and on no other cycle.
- R6: `beat_valid_o` is high for exactly the number of beats of one word (four at default width) per accepted word, with no gap, and low afterwards.
- R7: No request is acknowledged while beats are pending. After the last beat there is at least one idle cycle, and the next acknowledge and first beat come on the edge that follows it.
- R8: Changes to `data_i` after the capture edge do not alter the beats of the word being sent.
- R9: With `req_i` low, activity on `data_i` produces no beats and no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request from the asynchronous source |
| data_i | input | 27 | Input word, stable while `req_i` is high |
| ack_o | output | 1 | Acknowledge back to the source |
| beat_o | output | 8 | Output beat |
| beat_valid_o | output | 1 | Beat qualifier |
| frame_start_o | output | 1 | High on the first beat of a word |

## Verification
A wrong beat counter shows at the ports within one word: the frame is too long or too short, or the start flag lands on a later beat. A stuck handshake state shows as acknowledge failing to rise or fall within three edges of a request transition. Wrong shift-register contents show on the first beat of the affected word. The bench sweeps every column address against a set of hit patterns and checks every beat. A second, narrower instance makes the serializer slower than the handshake, which is the only way to show the hold-off of a new request.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

  typedef enum logic {
    HS_WAIT = 1'b0,
    HS_HELD = 1'b1
  } hs_state_e;

  localparam int DEF_IN_W   = 27;
  localparam int DEF_BEAT_W = 8;
  localparam int DEF_SYNC   = 2;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hbs_handshake.sv
module hbs_handshake #(
  parameter int IN_W = hbs_pkg::DEF_IN_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_s_i,
  input  logic            ser_idle_i,
  input  logic [IN_W-1:0] data_i,
  output logic            ack_o,
  output logic            cap_ev_o,
  output logic [IN_W-1:0] cap_word_o
);
  import hbs_pkg::*;

  hs_state_e state_q;
  logic      release_ev;

  assign cap_ev_o   = (state_q == HS_WAIT) && req_s_i && ser_idle_i;
  assign release_ev = (state_q == HS_HELD) && !req_s_i;
  assign cap_word_o = data_i;
  assign ack_o      = (state_q == HS_HELD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          state_q <= HS_WAIT;
    else if (cap_ev_o)   state_q <= HS_HELD;
    else if (release_ev) state_q <= HS_WAIT;
  end

  // R3
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && req_s_i) |=> ack_o);

  // R2
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(req_s_i));

  // R3
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_o) |-> !$past(req_s_i));
endmodule

// File: rtl/hbs_serializer.sv
module hbs_serializer #(
  parameter int IN_W   = hbs_pkg::DEF_IN_W,
  parameter int BEAT_W = hbs_pkg::DEF_BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [IN_W-1:0]   word_i,
  output logic [BEAT_W-1:0] beat_o,
  output logic              valid_o,
  output logic              sof_o,
  output logic              idle_o
);
  localparam int N_BEATS = hbs_pkg::ceil_div(IN_W, BEAT_W);
  localparam int PAD_W   = N_BEATS * BEAT_W;
  localparam int CNT_W   = $clog2(N_BEATS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(N_BEATS);

  logic [PAD_W-1:0] sh_q;
  logic [PAD_W-1:0] padded;
  logic [CNT_W-1:0] cnt_q;

  generate
    if (PAD_W == IN_W) begin : g_exact
      assign padded = word_i;
    end else begin : g_pad
      assign padded = {{(PAD_W-IN_W){1'b0}}, word_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= padded;
      cnt_q <= CNT_FULL;
    end else if (cnt_q != '0) begin
      sh_q  <= sh_q << BEAT_W;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign valid_o = (cnt_q != '0);
  assign idle_o  = (cnt_q == '0);
  assign sof_o   = (cnt_q == CNT_FULL);
  assign beat_o  = sh_q[PAD_W-1 -: BEAT_W];

  // R5
  sof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o |-> valid_o);

  // R5
  sof_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> sof_o);

  // R6
  beat_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !sof_o) |-> $past(valid_o));

  // R8
  beats_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !load_i && !sof_o) |-> (beat_o == $past(sh_q[PAD_W-BEAT_W-1 -: BEAT_W])));
endmodule

// File: rtl/hbs_conv_top.sv
module hbs_conv_top #(
  parameter int IN_W        = hbs_pkg::DEF_IN_W,
  parameter int BEAT_W      = hbs_pkg::DEF_BEAT_W,
  parameter int SYNC_STAGES = hbs_pkg::DEF_SYNC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [IN_W-1:0]   data_i,
  output logic              ack_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              beat_valid_o,
  output logic              frame_start_o
);
  logic            req_s;
  logic            ser_idle;
  logic            cap_ev;
  logic [IN_W-1:0] cap_word;

  hbs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (req_i),
    .q_o   (req_s)
  );

  hbs_handshake #(.IN_W(IN_W)) u_hs (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_s_i    (req_s),
    .ser_idle_i (ser_idle),
    .data_i     (data_i),
    .ack_o      (ack_o),
    .cap_ev_o   (cap_ev),
    .cap_word_o (cap_word)
  );

  hbs_serializer #(.IN_W(IN_W), .BEAT_W(BEAT_W)) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (cap_ev),
    .word_i  (cap_word),
    .beat_o  (beat_o),
    .valid_o (beat_valid_o),
    .sof_o   (frame_start_o),
    .idle_o  (ser_idle)
  );

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> (!$past(beat_valid_o) && frame_start_o));

  // R2
  cap_pairs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> (ack_o && frame_start_o));
endmodule

// File: tb/hbs_conv_top_tb_top.sv
`timescale 1ns/1ps
module hbs_conv_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [26:0] data = '0;
  logic        ack, vld, sof;
  logic [7:0]  beat;

  logic        req_n = 1'b0;
  logic [26:0] data_n = '0;
  logic        ack_n, vld_n, sof_n;
  logic [1:0]  beat_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  hbs_conv_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .data_i(data),
    .ack_o(ack), .beat_o(beat), .beat_valid_o(vld), .frame_start_o(sof)
  );

  hbs_conv_top #(.BEAT_W(2)) dut_n (
    .clk(clk), .rst_n(rst_n), .req_i(req_n), .data_i(data_n),
    .ack_o(ack_n), .beat_o(beat_n), .beat_valid_o(vld_n), .frame_start_o(sof_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_beat(input logic [26:0] w, input int idx);
    logic [31:0] p;
    p = {5'b00000, w};
    return p[8*(3-idx) +: 8];
  endfunction

  task automatic send_word(input logic [26:0] w);
    @(negedge clk);
    data = w;
    req  = 1'b1;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (k <= 2) begin
        chk(!ack && !vld, "R2 early", {30'd0, ack, vld}, 32'd0);
      end else if (k <= 6) begin
        chk(vld, "R6 valid", {31'd0, vld}, 32'd1);
        chk(sof == (k == 3), "R5 sof", {31'd0, sof}, {31'd0, k == 3});
        chk(beat == exp_beat(w, k - 3), "R4 beat", {24'd0, beat}, {24'd0, exp_beat(w, k - 3)});
        chk(ack, "R3 ack high", {31'd0, ack}, 32'd1);
        if (k == 3) data = ~w;
        if (k == 4) req = 1'b0;
      end else begin
        chk(!vld, "R6 end", {31'd0, vld}, 32'd0);
        chk(!ack, "R3 ack fall", {31'd0, ack}, 32'd0);
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ack && !vld && !sof, "R1 in reset", {29'd0, ack, vld, sof}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!ack && !vld && !sof, "R1 after reset", {29'd0, ack, vld, sof}, 32'd0);

    // R9: data activity with request low
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      data = 27'(i * 32'h0123_4567);
      chk(!ack && !vld, "R9 idle", {30'd0, ack, vld}, 32'd0);
    end

    // R4 R5 R6 R8 sweep over every column address and several hit patterns
    for (int col = 0; col < 32; col++) begin
      for (int hp = 0; hp < 6; hp++) begin
        logic [21:0] hit;
        hit = (hp == 0) ? 22'h0 : (hp == 1) ? 22'h3FFFFF :
              (hp == 2) ? 22'h2AAAAA : (hp == 3) ? 22'h155555 :
              22'(32'h1 << ((col + hp * 5) % 22)) ^ 22'(col * 977);
        send_word({5'(col), hit});
      end
    end

    // R1: reset in the middle of a frame
    @(negedge clk);
    data = 27'h7FFFFFF;
    req  = 1'b1;
    repeat (4) @(negedge clk);
    chk(vld, "R1 frame running", {31'd0, vld}, 32'd1);
    rst_n = 1'b0;
    req   = 1'b0;
    #0.5;
    chk(!ack && !vld && !sof, "R1 mid reset", {29'd0, ack, vld, sof}, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!ack && !vld, "R1 post reset", {30'd0, ack, vld}, 32'd0);

    // R7: narrow instance, fourteen beats per word, source re-requests early
    begin
      int k;
      int beats;
      int ack_at;
      k = 0; beats = 0; ack_at = 0;
      @(negedge clk);
      data_n = 27'h5A5A5A5;
      req_n  = 1'b1;
      while (k < 40 && ack_at == 0) begin
        @(negedge clk);
        k++;
        if (vld_n) beats++;
        if (k == 3) begin
          chk(ack_n && sof_n, "R2 narrow ack", {30'd0, ack_n, sof_n}, 32'd3);
          req_n = 1'b0;
        end
        if (k == 6) begin
          chk(!ack_n, "R3 narrow ack fall", {31'd0, ack_n}, 32'd0);
          req_n  = 1'b1;
          data_n = 27'h1234567;
        end
        if (k > 6 && ack_n) ack_at = k;
        if (k == 17) chk(!vld_n && !ack_n, "R7 idle gap", {30'd0, vld_n, ack_n}, 32'd0);
      end
      chk(ack_at == 18, "R7 second ack cycle", 32'(ack_at), 32'd18);
      chk(beats - (sof_n ? 1 : 0) == 14, "R6 narrow beats", 32'(beats - (sof_n ? 1 : 0)), 32'd14);
      chk(sof_n && beat_n == 2'b00, "R4 narrow first beat", {29'd0, sof_n, beat_n}, 32'd4);
      req_n = 1'b0;
      repeat (20) @(negedge clk);
      chk(!vld_n && !ack_n, "R6 narrow end", {30'd0, vld_n, ack_n}, 32'd0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule